// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block merges 64 interrupt request lines into one CPU interrupt and a single 6-bit vector number. There are two levels. A primary level has 32 slots. A secondary level takes 32 peripheral lines, which are sorted into three fixed groups, and each group drives one summary slot of the primary level. Every request line passes through a synchroniser first. Each bit is then either level-following or edge-capturing, and this choice is fixed by a parameter mask.

Software sees six registers: two masks, two edge-capture registers and two read-only status views. An edge capture is acknowledged by writing the capture register back with the bit in question cleared. A combinational resolver picks the winner and reports it as a vector number with a valid flag.

Register map (3-bit address):
- 0: primary mask.
- 1: secondary mask.
- 2: primary capture.
- 3: secondary capture.
- 4: primary status (read-only).
- 5: secondary status (read-only).
- Any other address reads as zero. Writes to read-only addresses are ignored.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, both masks and both capture registers read zero, vec_valid is low and cpu_irq is low.
- R2: A primary level bit (any bit outside 4–6 and outside the primary edge set) appears in primary status while its synchronised line is high, and it drops when the line drops.
- R3: Primary bits 16–19, 22–24 and 28–31 set their capture bit on a rising edge of the synchronised line. The bit stays set after the line falls.
- R4: Secondary bits 16, 22 and 28 capture rising edges in the same way. All other secondary bits follow their line, so a pulse on one of them leaves no trace in the secondary capture register.
- R5: A write to a capture register replaces its content with the written data ANDed with that register's edge set. Writing zero to a bit acknowledges it, and level bits can never be set this way.
- R6: If a new rising edge and a capture-register write land in the same cycle, the new edge stays set.
- R7: Primary status bits 4, 5 and 6 are not driven by primary lines. Each one is the OR of (secondary status AND secondary mask) over a fixed range: bit 4 covers secondary 16–31, bit 5 covers 8–15 and bit 6 covers 0–7.
- R8: When primary status AND primary mask is zero, vec_valid is low.
- R9: Otherwise, if that masked value has none of bits 4–6 set, vec_num is the index of its lowest set bit (0–31).
- R10: If the masked primary value has any of bits 4–6 set, vec_num is 32 plus the index of the lowest set bit of secondary status AND secondary mask. This holds even when a lower primary bit is also pending.
- R11: cpu_irq always equals vec_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prim_req | input | 32 | Primary request lines (bits 4–6 unused) |
| sec_req | input | 32 | Secondary request lines |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| vec_num | output | 6 | Winning vector number |
| vec_valid | output | 1 | Vector number is meaningful |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The resolver is tried with the following input patterns:
- Two primary level bits together, which shows that the lowest index wins.
- A masked-off request alone, which shows the spurious case produces no interrupt.
- Primary lines 4–6 driven directly, which shows those inputs are dead.
- A low primary bit together with a secondary request, which shows that the group path overrides primary priority.

For the capture registers:
- Single pulses show that edge bits are held and level bits are not.
- An all-ones write shows that only edge bits can be set.
- A write timed into the same cycle as a fresh edge shows that the new edge takes priority over the clear.

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] PRI_EDGE    = 32'hF1CF_0000,
  parameter logic [31:0] SEC_EDGE    = 32'h1041_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] prim_req,
  input  logic [31:0] sec_req,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [5:0]  vec_num,
  output logic        vec_valid,
  output logic        cpu_irq
);
  localparam int          W         = 32;
  localparam logic [W-1:0] GRP_BITS  = 32'h0000_0070;
  localparam logic [W-1:0] SEC_AUDIO = 32'h0000_00FF;
  localparam logic [W-1:0] SEC_MISC  = 32'h0000_FF00;
  localparam logic [W-1:0] SEC_SPAR  = 32'hFFFF_0000;
  localparam logic [W-1:0] PRI_LEVEL = ~PRI_EDGE & ~GRP_BITS;
  localparam logic [W-1:0] SEC_LEVEL = ~SEC_EDGE;
  localparam logic [2:0] A_PMASK = 3'd0, A_SMASK = 3'd1, A_PCAP = 3'd2,
                         A_SCAP  = 3'd3, A_PSTAT = 3'd4, A_SSTAT = 3'd5;

  logic [SYNC_STAGES-1:0][W-1:0] p_sync, s_sync;
  logic [W-1:0] p_prev, s_prev, p_rise, s_rise;
  logic [W-1:0] p_mask, s_mask, p_cap, s_cap;
  logic [W-1:0] p_stat, s_stat, p_pend, s_pend;
  logic [2:0]   grp;

  function automatic logic [4:0] lowest(input logic [W-1:0] v);
    logic [4:0] r = '0;
    for (int i = W - 1; i >= 0; i--)
      if (v[i]) r = i[4:0];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_sync <= '0;
      s_sync <= '0;
      p_prev <= '0;
      s_prev <= '0;
    end else begin
      p_sync[0] <= prim_req;
      s_sync[0] <= sec_req;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        p_sync[i] <= p_sync[i-1];
        s_sync[i] <= s_sync[i-1];
      end
      p_prev <= p_sync[SYNC_STAGES-1];
      s_prev <= s_sync[SYNC_STAGES-1];
    end
  end

  assign p_rise = p_sync[SYNC_STAGES-1] & ~p_prev & PRI_EDGE;
  assign s_rise = s_sync[SYNC_STAGES-1] & ~s_prev & SEC_EDGE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_mask <= '0;
      s_mask <= '0;
      p_cap  <= '0;
      s_cap  <= '0;
    end else begin
      if (reg_wr && reg_addr == A_PMASK) p_mask <= reg_wdata;
      if (reg_wr && reg_addr == A_SMASK) s_mask <= reg_wdata;
      p_cap <= (((reg_wr && reg_addr == A_PCAP) ? reg_wdata : p_cap) & PRI_EDGE) | p_rise;
      s_cap <= (((reg_wr && reg_addr == A_SCAP) ? reg_wdata : s_cap) & SEC_EDGE) | s_rise;
    end
  end

  assign s_stat = (s_sync[SYNC_STAGES-1] & SEC_LEVEL) | s_cap;
  assign s_pend = s_stat & s_mask;
  assign grp    = {|(s_pend & SEC_AUDIO), |(s_pend & SEC_MISC), |(s_pend & SEC_SPAR)};
  assign p_stat = (p_sync[SYNC_STAGES-1] & PRI_LEVEL) | p_cap | {25'd0, grp, 4'd0};
  assign p_pend = p_stat & p_mask;

  assign vec_valid = |p_pend;
  assign vec_num   = |(p_pend & GRP_BITS) ? {1'b1, lowest(s_pend)} : {1'b0, lowest(p_pend)};
  assign cpu_irq   = vec_valid;

  always_comb begin
    case (reg_addr)
      A_PMASK: reg_rdata = p_mask;
      A_SMASK: reg_rdata = s_mask;
      A_PCAP:  reg_rdata = p_cap;
      A_SCAP:  reg_rdata = s_cap;
      A_PSTAT: reg_rdata = p_stat;
      A_SSTAT: reg_rdata = s_stat;
      default: reg_rdata = '0;
    endcase
  end

  AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_PCAP) |=> ((p_cap & $past(p_cap)) == $past(p_cap))); // R3
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rise != '0) |=> ((s_cap & $past(s_rise)) == $past(s_rise))); // R6
  AST_PRI_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_num[5]) |-> (p_mask[vec_num[4:0]] && p_stat[vec_num[4:0]])); // R9
  AST_SEC_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_num[5]) |-> (s_mask[vec_num[4:0]] && s_stat[vec_num[4:0]])); // R10
  AST_SEC_WIN_NEEDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_num[5]) |-> ((p_pend & GRP_BITS) != '0)); // R10
  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (p_mask == '0) |-> !cpu_irq); // R8
endmodule

// File: tb/cascade_irq_ctrl_bench.sv
module cascade_irq_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic [31:0] prim_req = '0, sec_req = '0, reg_wdata = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 0;
  logic [31:0] reg_rdata;
  logic [5:0]  vec_num;
  logic        vec_valid, cpu_irq;
  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic v; logic [5:0] n; string tag; } exp_t;
  exp_t q[$];

  cascade_irq_ctrl u_cascade_irq_ctrl (.*);

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic expect_vec(logic v, logic [5:0] n, string tag);
    exp_t e;
    repeat (4) @(posedge clk);
    e.v = v; e.n = n; e.tag = tag;
    q.push_back(e);
    @(negedge clk); #2;
  endtask

  task automatic pulse_p(int b);
    @(negedge clk); prim_req[b] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); prim_req[b] = 0;
  endtask

  task automatic pulse_s(int b);
    @(negedge clk); sec_req[b] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); sec_req[b] = 0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        chk({e.tag, " valid"}, {31'd0, vec_valid}, {31'd0, e.v});
        if (e.v) chk({e.tag, " vec"}, {26'd0, vec_num}, {26'd0, e.n});
        chk("R11 irq", {31'd0, cpu_irq}, {31'd0, vec_valid});
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(3'd0, 0, "R1 pmask"); rd(3'd1, 0, "R1 smask");
    rd(3'd2, 0, "R1 pcap");  rd(3'd3, 0, "R1 scap");
    expect_vec(0, 0, "R1");
    wr(3'd0, 32'hFFFF_FFFF);
    expect_vec(0, 0, "R8 nothing pending");
    @(negedge clk); prim_req = 32'h0000_0208;
    expect_vec(1, 3, "R9 lowest");
    rd(3'd4, 32'h0000_0208, "R2 pstat");
    @(negedge clk); prim_req = 32'h0000_0200;
    expect_vec(1, 9, "R2 follow");
    wr(3'd0, 32'hFFFF_FDFF);
    expect_vec(0, 0, "R8 masked");
    @(negedge clk); prim_req = 32'h0000_0070;
    expect_vec(0, 0, "R7 dead inputs");
    rd(3'd4, 0, "R7 pstat dead");
    @(negedge clk); prim_req = 0;
    wr(3'd0, 32'hFFFF_FFFF);
    pulse_p(17);
    rd(3'd2, 32'h0002_0000, "R3 pcap");
    expect_vec(1, 17, "R3 held");
    // R6: capture write lands in the same cycle as the bit-18 edge
    @(negedge clk); prim_req[18] = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_addr = 3'd2; reg_wdata = 0; reg_wr = 1;
    @(posedge clk);
    @(negedge clk); reg_wr = 0; prim_req[18] = 0;
    rd(3'd2, 32'h0004_0000, "R6 pcap");
    expect_vec(1, 18, "R6");
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, 32'hF1CF_0000, "R5 edge only");
    expect_vec(1, 16, "R5 set");
    wr(3'd2, 0);
    rd(3'd2, 0, "R5 cleared");
    expect_vec(0, 0, "R5 ack");
    @(negedge clk); prim_req = 32'h0000_0004; sec_req = 32'h0000_0400;
    expect_vec(1, 2, "R7 smask off");
    rd(3'd4, 32'h0000_0004, "R7 pstat no grp");
    wr(3'd1, 32'hFFFF_FFFF);
    expect_vec(1, 42, "R10 group wins");
    rd(3'd4, 32'h0000_0024, "R7 misc grp");
    @(negedge clk); sec_req = 32'h0000_0408;
    expect_vec(1, 35, "R10 sec lowest");
    wr(3'd0, 32'hFFFF_FFBF);
    expect_vec(1, 35, "R10 other grp");
    wr(3'd0, 32'hFFFF_FFFF);
    @(negedge clk); prim_req = 0; sec_req = 0;
    expect_vec(0, 0, "R8 idle");
    pulse_s(22);
    rd(3'd3, 32'h0040_0000, "R4 scap");
    expect_vec(1, 54, "R4 sec edge");
    rd(3'd4, 32'h0000_0010, "R7 spar grp");
    pulse_s(23);
    rd(3'd3, 32'h0040_0000, "R4 level no cap");
    expect_vec(1, 54, "R4 still");
    wr(3'd3, 0);
    expect_vec(0, 0, "R5 sec ack");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule